// File: doc/BRIEF.md
# Banked Buffer Memory Self-Test Sequencer

This block tests a buffer memory that is larger than the window a host can see at one time. A bank register chooses which bank of the buffer appears in a word-addressed window. On a start pulse the sequencer runs four passes. It writes a distinct 16-bit pattern into every bank. It reselects each bank and reads the pattern back. It clears every bank to zero. It reselects each bank and confirms that every word reads zero.

The memory port is synchronous. It takes one request per cycle, and read data returns one cycle after the address. The first mismatching word stops the test. The sequencer then reports the bank, the word offset, the observed word and the expected word. When the pattern pass fails, the zero pass is not run. A one-cycle done pulse closes every run, and a pass or fail verdict stays valid until the next start. The bank count and the window depth are parameters.

Top module: `bank_mem_selftest`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `pass_o` and `fail_o` are low, and no memory request and no bank-register write is issued until a start.
- R2: In the pattern pass, word j of bank i receives `(i*0x1000 + j) mod 2^16`. Every bank is written before the first read of any pass, and no nonzero word is written after the first read.
- R3: Before each bank's sweep in every pass, there is exactly one bank-register write, which gives 4*NUM_BANKS writes per passing run. `bank_reg_o[BANK_W]` is the enable bit and is 1 on every write. `bank_reg_o[BANK_W-1:0]` holds the bank number. Memory accesses that follow address that bank.
- R4: Read data is taken as valid on the cycle after the read address is issued, and is compared against the word expected for that address.
- R5: The first mismatch in bank-major, then ascending-offset, order stops the test. The block then reports fail, with `fail_bank_o`, `fail_off_o`, `fail_obs_o` and `fail_exp_o` set for that word.
- R6: After a clean pattern pass, all banks are written with zero and then read back, and any nonzero word is reported as in R5. After a passing run the whole buffer holds zero, and exactly 2*NUM_BANKS*WIN_WORDS writes were made.
- R7: If the pattern pass fails, the zero passes are skipped, so only NUM_BANKS*WIN_WORDS writes are made.
- R8: `done_o` is high for exactly one cycle, with exactly one of `pass_o` and `fail_o` high. The verdict holds until the next accepted start. A passing run raises `done_o` 4*NUM_BANKS*(WIN_WORDS+1)+1 cycles after the clock edge that samples `start_i`.
- R9: `start_i` is ignored while a test runs: the run length and the verdict do not change.
- R10: `busy_o` is high from the cycle after the accepted start until `done_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| bank_wr_o | output | 1 | Bank register write strobe |
| bank_reg_o | output | BANK_W+1 | Bank register value: enable bit at the top, bank number below |
| mem_req_o | output | 1 | Window access request |
| mem_we_o | output | 1 | Write enable for the access |
| mem_addr_o | output | OFF_W | Word offset inside the window |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after a read request |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | Verdict: all passes clean |
| fail_o | output | 1 | Verdict: mismatch found |
| fail_bank_o | output | BANK_W | Bank of the first mismatch |
| fail_off_o | output | OFF_W | Word offset of the first mismatch |
| fail_obs_o | output | 16 | Word read at the first mismatch |
| fail_exp_o | output | 16 | Word expected at the first mismatch |

## Verification
The hardest situations to reach are a fault that only the zero pass can expose, and a mismatch on the very last word of a pass. On the last word the compare happens while the sequencer is already selecting the next bank or draining.

The bench's memory model therefore has a cell that silently drops writes of zero. That cell keeps its pattern value and is caught only in the final read sweep. The model can also corrupt read data at chosen locations. The bench places one or two such locations at random, and also directly at the first and the last word of the buffer, so it covers both the earliest-mismatch ordering and the late compare on the last word.

// File: rtl/bank_mem_selftest_pkg.sv
package bank_mem_selftest_pkg;
  typedef enum logic [1:0] {PH_PAT_WR, PH_PAT_RD, PH_ZER_WR, PH_ZER_RD} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_RUN, ST_DRAIN} state_e;

  localparam logic [31:0] BANK_STRIDE = 32'h1000;

  function automatic logic [15:0] pat_word(input logic [31:0] bank, input logic [31:0] off);
    logic [31:0] sum;
    sum = bank * BANK_STRIDE + off;
    return sum[15:0];
  endfunction
endpackage

// File: rtl/bank_mem_addr_gen.sv
module bank_mem_addr_gen #(
  parameter int NUM_BANKS = 8,
  parameter int WIN_WORDS = 4096,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OFF_W  = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              last_word_o,
  output logic              last_bank_o
);
  localparam logic [BANK_W-1:0] BANK_MAX = BANK_W'(NUM_BANKS - 1);
  localparam logic [OFF_W-1:0]  OFF_MAX  = OFF_W'(WIN_WORDS - 1);

  logic [BANK_W-1:0] bank_q;
  logic [OFF_W-1:0]  off_q;

  assign last_word_o = (off_q == OFF_MAX);
  assign last_bank_o = (bank_q == BANK_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      off_q  <= '0;
    end else if (clr_i) begin
      bank_q <= '0;
      off_q  <= '0;
    end else if (step_i) begin
      if (last_word_o) begin
        off_q  <= '0;
        bank_q <= last_bank_o ? '0 : bank_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  assign bank_o = bank_q;
  assign off_o  = off_q;
endmodule

// File: rtl/bank_mem_cmp.sv
module bank_mem_cmp #(
  parameter int BANK_W = 3,
  parameter int OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              issue_i,
  input  logic [15:0]       exp_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [15:0]       rdata_i,
  output logic              mis_o,
  output logic [BANK_W-1:0] fail_bank_o,
  output logic [OFF_W-1:0]  fail_off_o,
  output logic [15:0]       fail_obs_o,
  output logic [15:0]       fail_exp_o
);
  // one-cycle read latency: tag travels with the request
  logic              vld_q, hit_q;
  logic [15:0]       exp_q;
  logic [BANK_W-1:0] bank_q;
  logic [OFF_W-1:0]  off_q;

  assign mis_o = vld_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      exp_q  <= '0;
      bank_q <= '0;
      off_q  <= '0;
    end else begin
      vld_q <= issue_i && !clr_i;
      if (issue_i) begin
        exp_q  <= exp_i;
        bank_q <= bank_i;
        off_q  <= off_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q       <= 1'b0;
      fail_bank_o <= '0;
      fail_off_o  <= '0;
      fail_obs_o  <= '0;
      fail_exp_o  <= '0;
    end else if (clr_i) begin
      hit_q       <= 1'b0;
      fail_bank_o <= '0;
      fail_off_o  <= '0;
      fail_obs_o  <= '0;
      fail_exp_o  <= '0;
    end else if (mis_o && !hit_q) begin
      hit_q       <= 1'b1;
      fail_bank_o <= bank_q;
      fail_off_o  <= off_q;
      fail_obs_o  <= rdata_i;
      fail_exp_o  <= exp_q;
    end
  end
endmodule

// File: rtl/bank_mem_selftest.sv
module bank_mem_selftest
  import bank_mem_selftest_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int WIN_WORDS = 4096,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OFF_W  = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              bank_wr_o,
  output logic [BANK_W:0]   bank_reg_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [OFF_W-1:0]  mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [BANK_W-1:0] fail_bank_o,
  output logic [OFF_W-1:0]  fail_off_o,
  output logic [15:0]       fail_obs_o,
  output logic [15:0]       fail_exp_o
);
  state_e state_q;
  phase_e phase_q;
  logic   done_q, pass_q, fail_q;

  logic              start_ok, run, wr_phase, zero_phase, mis;
  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  off;
  logic              last_word, last_bank;
  logic [15:0]       exp_word;

  assign start_ok   = (state_q == ST_IDLE) && start_i;
  assign run        = (state_q == ST_RUN);
  assign wr_phase   = (phase_q == PH_PAT_WR) || (phase_q == PH_ZER_WR);
  assign zero_phase = (phase_q == PH_ZER_WR) || (phase_q == PH_ZER_RD);
  assign exp_word   = zero_phase ? 16'h0000 : pat_word(32'(bank), 32'(off));

  bank_mem_addr_gen #(
    .NUM_BANKS (NUM_BANKS),
    .WIN_WORDS (WIN_WORDS)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_ok),
    .step_i      (run),
    .bank_o      (bank),
    .off_o       (off),
    .last_word_o (last_word),
    .last_bank_o (last_bank)
  );

  bank_mem_cmp #(
    .BANK_W (BANK_W),
    .OFF_W  (OFF_W)
  ) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_ok),
    .issue_i     (run && !wr_phase && !mis),
    .exp_i       (exp_word),
    .bank_i      (bank),
    .off_i       (off),
    .rdata_i     (mem_rdata_i),
    .mis_o       (mis),
    .fail_bank_o (fail_bank_o),
    .fail_off_o  (fail_off_o),
    .fail_obs_o  (fail_obs_o),
    .fail_exp_o  (fail_exp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_PAT_WR;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SEL;
          phase_q <= PH_PAT_WR;
          pass_q  <= 1'b0;
          fail_q  <= 1'b0;
        end
        ST_SEL: state_q <= ST_RUN;
        ST_RUN: if (last_word) begin
          if (last_bank) begin
            phase_q <= phase_e'(phase_q + 2'd1);
            state_q <= (phase_q == PH_ZER_RD) ? ST_DRAIN : ST_SEL;
          end else begin
            state_q <= ST_SEL;
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          pass_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
      // first mismatch aborts the run from any active state
      if (mis && state_q != ST_IDLE) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        pass_q  <= 1'b0;
        fail_q  <= 1'b1;
      end
    end
  end

  assign bank_wr_o   = (state_q == ST_SEL);
  assign bank_reg_o  = {bank_wr_o, bank};
  assign mem_req_o   = run;
  assign mem_we_o    = run && wr_phase;
  assign mem_addr_o  = off;
  assign mem_wdata_o = exp_word;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;
endmodule

// File: rtl/bank_mem_selftest_chk.sv
module bank_mem_selftest_chk #(
  parameter int BANK_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            bank_wr_o,
  input logic [BANK_W:0] bank_reg_o,
  input logic            mem_req_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            pass_o,
  input logic            fail_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !bank_wr_o));

  a_r3_bank_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_wr_o |-> bank_reg_o[BANK_W]);

  a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !bank_wr_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_one_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o ^ fail_o));

  a_r8_verdict_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o)));

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  a_r10_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind bank_mem_selftest bank_mem_selftest_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .bank_wr_o  (bank_wr_o),
  .bank_reg_o (bank_reg_o),
  .mem_req_o  (mem_req_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o)
);

// File: tb/tb_bank_mem_selftest.sv
`timescale 1ns/1ps
module tb_bank_mem_selftest;
  localparam int B  = 4;
  localparam int W  = 64;
  localparam int BW = 2;
  localparam int OW = 6;
  localparam int PASS_LAT = 4 * B * (W + 1) + 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          bank_wr_o;
  logic [BW:0]   bank_reg_o;
  logic          mem_req_o, mem_we_o;
  logic [OW-1:0] mem_addr_o;
  logic [15:0]   mem_wdata_o;
  logic [15:0]   mem_rdata_i = '0;
  logic          busy_o, done_o, pass_o, fail_o;
  logic [BW-1:0] fail_bank_o;
  logic [OW-1:0] fail_off_o;
  logic [15:0]   fail_obs_o, fail_exp_o;

  always #2 clk_i = ~clk_i;

  bank_mem_selftest #(.NUM_BANKS(B), .WIN_WORDS(W)) dut (.*);

  int total = 0;
  int bad   = 0;

  // memory model and fault controls
  logic [15:0] mem [B*W];
  int    cur_bank = 0;
  bit    bank_on = 0;
  int    wr_cnt, bank_wr_cnt, bank_off_err, access_err, order_err;
  bit    saw_read, snap_done;
  bit    xa_en, xb_en, st_en;
  int    xa_idx, xb_idx, st_idx;
  logic [15:0] xa_mask, xb_mask;
  int    idx;

  function automatic logic [15:0] pat(int b, int o);
    return 16'((b * 32'h1000 + o));
  endfunction

  function automatic logic [15:0] xor_of(int i);
    logic [15:0] m;
    m = '0;
    if (xa_en && i == xa_idx) m = m ^ xa_mask;
    if (xb_en && i == xb_idx) m = m ^ xb_mask;
    return m;
  endfunction

  always @(posedge clk_i) begin
    if (bank_wr_o) begin
      cur_bank <= int'(bank_reg_o[BW-1:0]);
      bank_on  <= bank_reg_o[BW];
      bank_wr_cnt++;
      if (!bank_reg_o[BW]) bank_off_err++;
    end
    if (mem_req_o) begin
      idx = cur_bank * W + int'(mem_addr_o);
      if (!bank_on) access_err++;
      if (mem_we_o) begin
        wr_cnt++;
        if (saw_read && mem_wdata_o != 16'h0) order_err++;
        if (!(st_en && idx == st_idx && mem_wdata_o == 16'h0)) mem[idx] <= mem_wdata_o;
      end else begin
        saw_read    <= 1'b1;
        mem_rdata_i <= mem[idx] ^ xor_of(idx);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R2: before the first read, every bank holds its pattern
  always @(negedge clk_i) begin
    if (mem_req_o && !mem_we_o && !snap_done) begin
      int errs = 0;
      snap_done = 1'b1;
      for (int i = 0; i < B * W; i++) if (mem[i] != pat(i / W, i % W)) errs++;
      chk(errs == 0, "R2", "pattern image at first read", errs, 0);
    end
  end

  task automatic prep();
    for (int i = 0; i < B * W; i++) mem[i] = 16'hdead;
    wr_cnt = 0; bank_wr_cnt = 0; bank_off_err = 0; access_err = 0; order_err = 0;
    saw_read = 0; snap_done = 0;
    xa_en = 0; xb_en = 0; st_en = 0;
  endtask

  task automatic run_once(input bit poke_mid, output int cyc, output int busy_err);
    @(negedge clk_i) start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) start_i = 1'b0;
    cyc = 0; busy_err = 0;
    forever begin
      cyc++;
      if (done_o) break;
      if (!busy_o) busy_err++;
      start_i = poke_mid && (cyc == 300 || cyc == 301);
      if (cyc > 6000) break;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(done_o, "R8", "done seen before timeout", int'(done_o), 1);
  endtask

  task automatic check_fail(input string req, input int b, input int o, input logic [15:0] obs,
                            input logic [15:0] exp, input int writes);
    chk(fail_o && !pass_o, req, "fail verdict", {pass_o, fail_o}, 1);
    chk(int'(fail_bank_o) == b, req, "fail bank", int'(fail_bank_o), b);
    chk(int'(fail_off_o) == o, req, "fail offset", int'(fail_off_o), o);
    chk(fail_obs_o == obs, req, "observed word", int'(fail_obs_o), int'(obs));
    chk(fail_exp_o == exp, req, "expected word", int'(fail_exp_o), int'(exp));
    chk(wr_cnt == writes, req, "write count", wr_cnt, writes);
  endtask

  task automatic pass_run(input bit poke_mid, input string tag);
    int cyc, busy_err, zeros;
    prep();
    run_once(poke_mid, cyc, busy_err);
    chk(pass_o && !fail_o, "R8", {tag, " pass verdict (R4 one-cycle read)"}, {pass_o, fail_o}, 2);
    chk(cyc == PASS_LAT, poke_mid ? "R9" : "R8", {tag, " done latency"}, cyc, PASS_LAT);
    chk(busy_err == 0, "R10", {tag, " busy during run"}, busy_err, 0);
    zeros = 0;
    for (int i = 0; i < B * W; i++) if (mem[i] == 16'h0) zeros++;
    chk(zeros == B * W, "R6", {tag, " buffer cleared"}, zeros, B * W);
    chk(wr_cnt == 2 * B * W, "R6", {tag, " write count"}, wr_cnt, 2 * B * W);
    chk(bank_wr_cnt == 4 * B, "R3", {tag, " bank writes"}, bank_wr_cnt, 4 * B);
    chk(bank_off_err + access_err == 0, "R3", {tag, " enable bit and access"}, bank_off_err + access_err, 0);
    chk(order_err == 0, "R2", {tag, " no pattern write after read"}, order_err, 0);
    chk(fail_bank_o == '0 && fail_off_o == '0, "R5", {tag, " no fail info"}, int'(fail_off_o), 0);
    @(negedge clk_i);
    chk(!done_o && pass_o, "R8", {tag, " pulse width and hold"}, {done_o, pass_o}, 1);
  endtask

  task automatic xor_run(input int ia, input int ib, input bit two, input logic [15:0] ma,
                         input logic [15:0] mb);
    int cyc, busy_err, first;
    logic [15:0] m;
    prep();
    xa_en = 1; xa_idx = ia; xa_mask = ma;
    xb_en = two; xb_idx = ib; xb_mask = mb;
    run_once(1'b0, cyc, busy_err);
    first = (two && ib < ia) ? ib : ia;
    m = (first == ia) ? ma : mb;
    if (two && ia == ib) m = ma ^ mb;
    check_fail(two ? "R5" : "R7", first / W, first % W, pat(first / W, first % W) ^ m,
               pat(first / W, first % W), B * W);
  endtask

  task automatic stuck_run(input int s);
    int cyc, busy_err;
    prep();
    st_en = 1; st_idx = s;
    run_once(1'b0, cyc, busy_err);
    check_fail("R6", s / W, s % W, pat(s / W, s % W), 16'h0, 2 * B * W);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    prep();
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o, "R1", "idle after reset", {busy_o, done_o}, 0);
    chk(!pass_o && !fail_o, "R1", "no verdict after reset", {pass_o, fail_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(!mem_req_o && !bank_wr_o, "R1", "no access without start", {mem_req_o, bank_wr_o}, 0);
    chk(wr_cnt + bank_wr_cnt == 0, "R1", "no writes while idle", wr_cnt + bank_wr_cnt, 0);

    pass_run(1'b0, "plain");
    pass_run(1'b1, "start poked mid-run");

    // corner faults: first word and last word of the buffer
    xor_run(0, 0, 1'b0, 16'h0001, 16'h0);
    xor_run(B * W - 1, 0, 1'b0, 16'h8000, 16'h0);
    stuck_run(B * W - 1);
    stuck_run(1);

    // random single and double read faults, random stuck cells
    for (int k = 0; k < 6; k++) begin
      int a = int'($urandom % (B * W));
      logic [15:0] m = 16'($urandom % 16'hffff) + 16'd1;
      xor_run(a, 0, 1'b0, m, 16'h0);
    end
    for (int k = 0; k < 4; k++) begin
      int a = int'($urandom % (B * W));
      int b = int'($urandom % (B * W));
      if (a == b) b = (a + 5) % (B * W);
      xor_run(a, b, 1'b1, 16'h0100 << (k % 8), 16'h0003);
    end
    for (int k = 0; k < 3; k++) begin
      int s = 1 + int'($urandom % (B * W - 1));
      stuck_run(s);
    end

    pass_run(1'b0, "after faults");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule